// File: doc/BRIEF.md
# Four-Slot TDM PCM Serial Port

This block is the serial PCM data interface of a four-channel codec. A data clock paces the line, and a frame sync pulse that recurs once per frame marks each frame start. From the rising edge on which frame sync is first seen high, the port drives four 8-bit transmit codes one after another on a shared serial line. Each code goes out MSB first, channel 1 first. It enables the line driver only during the slot of a channel that is powered up. After the 32nd bit it releases the line until the next frame.

In the same slot positions, the port samples the receive line on falling clock edges. After the last bit of a frame it updates all four receive bytes at once and raises a one-cycle done strobe. Receive bytes of powered-down channels keep their old value. Transmit bytes and the power mask are captured at frame start, so the parallel side may change them at any time during a frame. Companding and the analog paths sit outside this block.

Top module: `pcm_tdm_port`

## Requirements
- R1: While and right after reset, `tx_oe`, `tx_bit`, `rx_done` and all of `rx_codes` are 0.
- R2: A frame starts on a rising clock edge where `fsync` is 1 and was 0 at the previous edge. Channel 1's MSB is driven in the cycle that follows. An `fsync` held high for more than one edge starts only one frame.
- R3: In the cycle after the (k+1)-th edge of a frame (k = 0..31), `tx_bit` carries bit 7-(k mod 8) of channel k/8. Channel i (0-based) occupies `tx_codes[8i+7:8i]`.
- R4: `tx_oe` is 0 from the 33rd edge of a frame until the next frame start.
- R5: A channel whose `chan_on` bit is 0 at frame start is not driven in its slot (`tx_oe` = 0).
- R6: `tx_bit` is 0 in every cycle in which `tx_oe` is 0.
- R7: `tx_codes` and `chan_on` are captured at the frame-start edge. Changes to them later in the frame have no effect on that frame.
- R8: Bit k of the receive stream is sampled on the falling edge within slot k and is assembled MSB first into `rx_codes`, using the same channel layout as R3.
- R9: `rx_codes` changes only on the 33rd edge of a frame, all channels together, and `rx_done` is 1 for exactly the one cycle after that edge, even when all channels are off. At all other times `rx_codes` is stable.
- R10: The receive byte of a channel that was off at frame start keeps its previous value.
- R11: A frame start during an active frame restarts the slot count at channel 1's MSB. The abandoned partial frame updates nothing and raises no `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; transmit changes on rising edges, receive samples on falling edges |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync; its low-to-high transition seen at a rising edge starts a frame |
| chan_on | input | 4 | Per-channel power state, 1 = powered up, bit i = channel i |
| tx_codes | input | 32 | Transmit codes, channel i at bits [8i+7:8i] |
| rx_bit | input | 1 | Serial receive line |
| tx_bit | output | 1 | Serial transmit data, 0 while not enabled |
| tx_oe | output | 1 | Tri-state enable for the transmit line driver |
| rx_codes | output | 32 | Receive codes, channel i at bits [8i+7:8i] |
| rx_done | output | 1 | One-cycle strobe when `rx_codes` has been updated |

## Verification
The properties take for granted that `fsync` stays low for at least 33 edges between frame starts, except where a restart is meant. They also assume a frame start is flagged by a clean low-to-high transition of `fsync` at a rising edge, and that `rx_bit` is settled around each falling edge. The bench changes every input one nanosecond after a rising edge, well clear of the falling sample point. It drops `fsync` after the start edge in all vectors, and raises it early on purpose only in the restart and held-sync cases. The held-sync case confirms that a wide pulse produces one start, and the restart case shows that a second start inside a frame abandons the partial receive.

// File: rtl/pcm_tdm_pkg.sv
// Shared constants for the TDM PCM port.
// Assumes the code width is a power of two so a slot index splits cleanly
// into a channel field and a bit field.
package pcm_tdm_pkg;
    localparam int unsigned PCM_NUM_CH = 4;
    localparam int unsigned PCM_CODE_W = 8;
endpackage

// File: rtl/pcm_slot_timer.sv
// Frame slot timer: detects a frame start from the frame-sync input and
// counts the NUM_CH*CODE_W bit slots that follow it.
// Assumes: fsync is synchronous to clk; a new start restarts the count.
module pcm_slot_timer #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned SLOTS = NUM_CH * CODE_W,
    localparam int unsigned CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             frame_start,
    output logic             active,
    output logic [CNT_W-1:0] slot_idx,
    output logic             last_slot
);
    logic fsync_q;

    assign frame_start = fsync && !fsync_q;
    assign last_slot   = active && (slot_idx == CNT_W'(SLOTS - 1));

    // Remember the previous frame-sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fsync_q <= 1'b0;
        else        fsync_q <= fsync;
    end

    // Run the slot counter from a frame start to the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            slot_idx <= '0;
        end else if (frame_start) begin
            active   <= 1'b1;
            slot_idx <= '0;
        end else if (active) begin
            if (last_slot) begin
                active   <= 1'b0;
                slot_idx <= '0;
            end else begin
                slot_idx <= slot_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
// Transmit serializer: captures the transmit codes and the power mask at
// frame start, then shifts the codes out MSB first, channel 0 first, with
// the line enabled only for powered-up channels.
// Assumes CODE_W is a power of two.
module pcm_tx_serializer #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned SLOTS = NUM_CH * CODE_W,
    localparam int unsigned CNT_W = $clog2(SLOTS),
    localparam int unsigned BIT_W = $clog2(CODE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             active,
    input  logic [CNT_W-1:0] slot_idx,
    input  logic [SLOTS-1:0] tx_codes,
    input  logic [NUM_CH-1:0] chan_on,
    output logic [NUM_CH-1:0] mask_q,
    output logic             tx_oe,
    output logic             tx_bit
);
    logic [SLOTS-1:0]       shadow_q;
    logic [CNT_W-BIT_W-1:0] ch_sel;
    logic [BIT_W-1:0]       bit_sel;

    assign ch_sel  = slot_idx[CNT_W-1:BIT_W];
    assign bit_sel = slot_idx[BIT_W-1:0];

    // Capture the frame's codes and power mask at the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            mask_q   <= '0;
        end else if (frame_start) begin
            shadow_q <= tx_codes;
            mask_q   <= chan_on;
        end
    end

    // Drive the selected bit only inside a powered-up channel's slot.
    always_comb begin
        tx_oe  = active && mask_q[ch_sel];
        tx_bit = tx_oe && shadow_q[{ch_sel, ~bit_sel}];
    end
endmodule

// File: rtl/pcm_rx_deserializer.sv
// Receive deserializer: samples the line on the falling clock edge,
// shifts the frame in on the rising edge and commits all channels at once
// after the last slot, skipping channels that were off at frame start.
// Assumes the slot timer's active/last_slot describe the current slot.
module pcm_rx_deserializer #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned SLOTS = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              active,
    input  logic              last_slot,
    input  logic [NUM_CH-1:0] mask_q,
    input  logic              rx_bit,
    output logic [SLOTS-1:0]  rx_codes,
    output logic              rx_done
);
    logic             rx_smp;
    logic [SLOTS-1:0] shift_q;
    logic [SLOTS-1:0] frame_bits;

    assign frame_bits = {shift_q[SLOTS-2:0], rx_smp};

    // Sample the receive line mid-bit on the falling edge.
    always_ff @(negedge clk) begin
        rx_smp <= rx_bit;
    end

    // Shift each sampled bit in while a frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n)                      shift_q <= '0;
        else if (active && !frame_start) shift_q <= frame_bits;
    end

    // Commit the assembled frame per channel and pulse done once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_codes <= '0;
            rx_done  <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (last_slot && !frame_start) begin
                rx_done <= 1'b1;
                for (int i = 0; i < NUM_CH; i++) begin
                    if (mask_q[i])
                        rx_codes[i*CODE_W +: CODE_W] <=
                            frame_bits[SLOTS-1-i*CODE_W -: CODE_W];
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tdm_port.sv
// Four-slot TDM PCM serial port top: ties the slot timer, transmit
// serializer and receive deserializer together.
// Assumes clk is the data clock and fsync is synchronous to it.
module pcm_tdm_port #(
    parameter int unsigned NUM_CH = pcm_tdm_pkg::PCM_NUM_CH,
    parameter int unsigned CODE_W = pcm_tdm_pkg::PCM_CODE_W,
    localparam int unsigned SLOTS = NUM_CH * CODE_W,
    localparam int unsigned CNT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [NUM_CH-1:0] chan_on,
    input  logic [SLOTS-1:0]  tx_codes,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic              tx_oe,
    output logic [SLOTS-1:0]  rx_codes,
    output logic              rx_done
);
    logic              frame_start;
    logic              active;
    logic              last_slot;
    logic [CNT_W-1:0]  slot_idx;
    logic [NUM_CH-1:0] mask_q;

    pcm_slot_timer #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .frame_start(frame_start),
        .active     (active),
        .slot_idx   (slot_idx),
        .last_slot  (last_slot)
    );

    pcm_tx_serializer #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .active     (active),
        .slot_idx   (slot_idx),
        .tx_codes   (tx_codes),
        .chan_on    (chan_on),
        .mask_q     (mask_q),
        .tx_oe      (tx_oe),
        .tx_bit     (tx_bit)
    );

    pcm_rx_deserializer #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .active     (active),
        .last_slot  (last_slot),
        .mask_q     (mask_q),
        .rx_bit     (rx_bit),
        .rx_codes   (rx_codes),
        .rx_done    (rx_done)
    );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
// Property checker for the TDM PCM port, bound to every instance.
// Assumes the same frame-start rule as the port; keeps its own slot count.
module pcm_tdm_port_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned SLOTS = NUM_CH * CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic [NUM_CH-1:0] chan_on,
    input logic [SLOTS-1:0]  tx_codes,
    input logic              tx_oe,
    input logic              tx_bit,
    input logic [SLOTS-1:0]  rx_codes,
    input logic              rx_done
);
    logic       fs_prev;
    logic       start;
    logic [6:0] since;

    assign start = fsync && !fs_prev;

    // Track the checker's own view of slots elapsed since frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            since   <= '0;
        end else begin
            fs_prev <= fsync;
            if (start)                                    since <= 7'd1;
            else if (since != 0 && since <= 7'(SLOTS + 2)) since <= since + 1'b1;
        end
    end

    AST_MSB_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start && chan_on[0] |=> tx_oe && (tx_bit == $past(tx_codes[CODE_W-1]))); // R2
    AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> (since >= 7'd1 && since <= 7'(SLOTS))); // R4
    AST_OFF_SLOT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        start && !chan_on[0] |=> !tx_oe); // R5
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_bit); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R9
    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_codes)); // R9
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .chan_on (chan_on),
    .tx_codes(tx_codes),
    .tx_oe   (tx_oe),
    .tx_bit  (tx_bit),
    .rx_codes(rx_codes),
    .rx_done (rx_done)
);

// File: tb/pcm_tdm_port_test.sv
`timescale 1ns/1ps
module pcm_tdm_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [3:0]  chan_on = 4'h0;
    logic [31:0] tx_codes = 32'h0;
    logic        rx_bit = 1'b0;
    logic        tx_bit, tx_oe, rx_done;
    logic [31:0] rx_codes;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = 32'h0;
    bit finished = 1'b0;

    pcm_tdm_port uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .chan_on(chan_on),
        .tx_codes(tx_codes), .rx_bit(rx_bit), .tx_bit(tx_bit),
        .tx_oe(tx_oe), .rx_codes(rx_codes), .rx_done(rx_done)
    );

    always #2.5 clk = ~clk;

    // fields: [68] change inputs mid-frame, [67:64] mask, [63:32] tx, [31:0] rx
    localparam logic [68:0] VEC [0:4] = '{
        {1'b0, 4'hF, 32'h1234_5678, 32'h9ABC_DEF0},
        {1'b0, 4'hF, 32'hFF00_A55A, 32'h0FF0_3CC3},
        {1'b0, 4'h5, 32'hDEAD_BEEF, 32'h1122_3344},
        {1'b1, 4'hF, 32'h8001_7FFE, 32'hAAAA_5555},
        {1'b0, 4'h0, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input logic [31:0] tx, input logic [3:0] mask,
                             input logic [31:0] rx, input bit midchg);
        fsync = 1'b1; tx_codes = tx; chan_on = mask;
        step();
        fsync = 1'b0;
        for (int k = 0; k < 32; k++) begin
            int ch = k / 8;
            logic eoe, ebit;
            rx_bit = rx[ch*8 + 7 - (k % 8)];
            if (midchg && k == 4) begin tx_codes = ~tx; chan_on = 4'h0; end
            eoe  = mask[ch];
            ebit = eoe & tx[ch*8 + 7 - (k % 8)];
            chk(tx_oe == eoe, "R5/R7 tx_oe in slot", 32'(tx_oe), 32'(eoe));
            chk(tx_bit == ebit, "R3/R6/R7 tx_bit in slot", 32'(tx_bit), 32'(ebit));
            chk(rx_done == 1'b0, "R9 no done mid-frame", 32'(rx_done), 32'h0);
            step();
        end
        for (int i = 0; i < 4; i++)
            if (mask[i]) model[i*8 +: 8] = rx[i*8 +: 8];
        chk(tx_oe == 1'b0, "R4 released at 33rd edge", 32'(tx_oe), 32'h0);
        chk(rx_done == 1'b1, "R9 done after 33rd edge", 32'(rx_done), 32'h1);
        chk(rx_codes == model, "R8/R10 rx_codes", rx_codes, model);
        step();
        chk(rx_done == 1'b0, "R9 done one cycle", 32'(rx_done), 32'h0);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk(tx_oe == 1'b0 && tx_bit == 1'b0, "R1 tx idle in reset", {tx_oe, tx_bit}, 32'h0);
        rst_n = 1'b1;
        step();
        chk(rx_codes == 32'h0, "R1 rx_codes reset", rx_codes, 32'h0);
        chk(rx_done == 1'b0 && tx_oe == 1'b0, "R1 strobes reset", {rx_done, tx_oe}, 32'h0);

        // vector table walk
        for (int v = 0; v < 5; v++) begin
            run_frame(VEC[v][63:32], VEC[v][67:64], VEC[v][31:0], VEC[v][68]);
            repeat (3) step();
        end

        // R4: line stays released between frames
        for (int i = 0; i < 20; i++) begin
            chk(tx_oe == 1'b0 && tx_bit == 1'b0, "R4 idle between frames", {tx_oe, tx_bit}, 32'h0);
            step();
        end

        // R11: restart mid-frame abandons the partial frame
        fsync = 1'b1; tx_codes = 32'h0F0F_0F0F; chan_on = 4'hF;
        step();
        fsync = 1'b0;
        for (int k = 0; k < 10; k++) begin
            rx_bit = 1'b1;
            chk(rx_done == 1'b0, "R11 no done in aborted frame", 32'(rx_done), 32'h0);
            step();
        end
        run_frame(32'hC3C3_3C3C, 4'hF, 32'h5A5A_A5A5, 1'b0);
        repeat (3) step();

        // R2: a wide fsync pulse starts one frame only
        fsync = 1'b1; tx_codes = 32'h0000_00A5; chan_on = 4'hF;
        step();
        chk(tx_oe && tx_bit == 1'b1, "R2 MSB after start", {tx_oe, tx_bit}, 32'h3);
        step();
        fsync = 1'b0;
        chk(tx_oe && tx_bit == 1'b0, "R2 held sync no restart", {tx_oe, tx_bit}, 32'h2);
        repeat (31) step();
        chk(rx_done == 1'b1 && tx_oe == 1'b0, "R2 frame ends on schedule", {rx_done, tx_oe}, 32'h2);
        step();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule